// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block links two processor sides, A and B, through a pair of identical 32-bit register ports. Each side can post a word into one of four outgoing data slots. The word turns up in the matching incoming slot on the opposite side. A full/empty pair of status bits tracks every slot, so neither side needs a separate handshake to know when a word has arrived or has been consumed.

Besides data, each side can ring four doorbells toward its peer and can show three flag bits to it. A doorbell stays pending on the receiver until the receiver acknowledges it. The acknowledge also retires the request seen by the sender. Each side has one interrupt output. It is the OR of those status conditions whose enable bits the side has set in its own control register.

Register words (byte offsets): outgoing slot n at 0x00+4n, incoming slot n at 0x10+4n, status at 0x20, control at 0x24. Reads return data in the same cycle that the read strobe is high. All side effects take place at the next rising clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both control registers read 0x00000000 and both interrupt outputs are low. Both status registers read 0x00F00000: all empty bits are set and no full or pending bit is set.
- R2: When a side writes outgoing slot n, from the next cycle:
  - that side's status bit 20+(3−n) (empty) is clear;
  - the peer's status bit 24+(3−n) (full) is set;
  - the peer's incoming slot n returns the written word.
  A second write before the word is consumed overwrites the word, and the slot stays full.
- R3: When a side reads incoming slot n, from the next cycle its full bit 24+(3−n) is clear and the sender's empty bit 20+(3−n) is set again.
- R4: The control register holds the following fields, each with channel n at the reversed position shown. Enable and flag fields read back what was last written.

  | Field | Bit for channel n |
  |---|---|
  | doorbell interrupt enable | 28+(3−n) |
  | full interrupt enable | 24+(3−n) |
  | empty interrupt enable | 20+(3−n) |
  | outgoing doorbell request | 16+(3−n) |
  | flags | bits 2:0 |

- R5: Writing control with request bit 16+(3−n) set does two things from the next cycle: the writer's control reads that bit as 1, and the peer's status bit 28+(3−n) (pending) is set. Writing 0 to a request bit does not withdraw a request.
- R6: Writing status with a 1 at bit 28+(3−n) clears that pending bit and the originating side's request bit. Writing 0 there leaves the pending bit set.
- R7: A side's interrupt output is high exactly when at least one of its pending, full or empty status bits is set together with the matching enable bit.
- R8: Control bits 2:0 written by one side are readable in the peer's status bits 2:0 from the next cycle.
- R9: A status write changes only pending bits. Full bits, empty bits, flag bits and bit 9 are read-only, and bit 9 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_addr_i | input | 6 | Side A byte address |
| a_wr_i | input | 1 | Side A write strobe |
| a_rd_i | input | 1 | Side A read strobe |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data |
| a_irq_o | output | 1 | Side A interrupt |
| b_addr_i | input | 6 | Side B byte address |
| b_wr_i | input | 1 | Side B write strobe |
| b_rd_i | input | 1 | Side B read strobe |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data |
| b_irq_o | output | 1 | Side B interrupt |

## Verification
The hardest state to reach from the ports is a mix of unrelated status bits on one side. An example is an incoming word left unread while the peer's flags are nonzero, with a status write of all ones applied on top. In that state a wrong clear or a wrong bit lane changes a value that is otherwise never seen. The stimulus builds this state in steps. The peer posts a word and leaves it unread, and the peer's flags are set. The side then writes all ones to its status register and reads it back. Doorbell clears are reached along a similar path. The enable is set only after the pending bit is already raised, so that the bench observes the interrupt rising from a masked source, and observes it falling on the write-one clear.

// File: rtl/ipc_mb_pkg.sv
package ipc_mb_pkg;
  localparam int NCH       = 4;
  localparam int DW        = 32;
  localparam int AW        = 6;
  localparam int WW        = AW - 2;
  localparam int NFLAG     = 3;
  localparam int GIP_BASE  = 28;
  localparam int RF_BASE   = 24;
  localparam int TE_BASE   = 20;
  localparam int GIR_BASE  = 16;
  localparam logic [WW-1:0] W_STAT = WW'(2 * NCH);
  localparam logic [WW-1:0] W_CTRL = WW'(2 * NCH + 1);
endpackage

// File: rtl/mb_lane.sv
module mb_lane #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (wr_i) begin
      data_o <= wdata_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  a_r2_wr_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
  a_r2_wr_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> data_o == $past(wdata_i));
  a_r3_rd_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !full_o);
endmodule

// File: rtl/mb_bell.sv
module mb_bell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // new request wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end

  a_r5_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  a_r6_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(pend_o));
endmodule

// File: rtl/mb_port.sv
module mb_port
  import ipc_mb_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic                    irq_o,
  output logic [NCH-1:0]          tx_wr_o,
  output logic [NCH-1:0]          rx_rd_o,
  output logic [NCH-1:0]          gir_set_o,
  output logic [NCH-1:0]          gip_clr_o,
  output logic [NFLAG-1:0]        flags_o,
  input  logic [NCH-1:0]          tx_full_i,
  input  logic [NCH-1:0]          rx_full_i,
  input  logic [NCH-1:0][DW-1:0]  rx_data_i,
  input  logic [NCH-1:0]          gir_i,
  input  logic [NCH-1:0]          gip_i,
  input  logic [NFLAG-1:0]        peer_flags_i
);
  logic [WW-1:0]    word;
  logic             ctrl_wr, stat_wr;
  logic [NCH-1:0]   gie_q, rie_q, tie_q;
  logic [NFLAG-1:0] flag_q;
  logic [DW-1:0]    stat_v, ctrl_v;

  assign word    = addr_i[AW-1:2];
  assign ctrl_wr = wr_i && (word == W_CTRL);
  assign stat_wr = wr_i && (word == W_STAT);
  assign flags_o = flag_q;

  always_comb begin
    stat_v = '0;
    ctrl_v = '0;
    for (int n = 0; n < NCH; n++) begin
      stat_v[GIP_BASE + NCH - 1 - n] = gip_i[n];
      stat_v[RF_BASE  + NCH - 1 - n] = rx_full_i[n];
      stat_v[TE_BASE  + NCH - 1 - n] = ~tx_full_i[n];
      ctrl_v[GIP_BASE + NCH - 1 - n] = gie_q[n];
      ctrl_v[RF_BASE  + NCH - 1 - n] = rie_q[n];
      ctrl_v[TE_BASE  + NCH - 1 - n] = tie_q[n];
      ctrl_v[GIR_BASE + NCH - 1 - n] = gir_i[n];
      tx_wr_o[n]   = wr_i && (word == WW'(n));
      rx_rd_o[n]   = rd_i && (word == WW'(NCH + n));
      gir_set_o[n] = ctrl_wr && wdata_i[GIR_BASE + NCH - 1 - n];
      gip_clr_o[n] = stat_wr && wdata_i[GIP_BASE + NCH - 1 - n];
    end
    stat_v[NFLAG-1:0] = peer_flags_i;
    ctrl_v[NFLAG-1:0] = flag_q;
  end

  always_comb begin
    rdata_o = '0;
    if (word == W_STAT)      rdata_o = stat_v;
    else if (word == W_CTRL) rdata_o = ctrl_v;
    else begin
      for (int n = 0; n < NCH; n++)
        if (word == WW'(NCH + n)) rdata_o = rx_data_i[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= '0;
      rie_q  <= '0;
      tie_q  <= '0;
      flag_q <= '0;
    end else if (ctrl_wr) begin
      for (int n = 0; n < NCH; n++) begin
        gie_q[n] <= wdata_i[GIP_BASE + NCH - 1 - n];
        rie_q[n] <= wdata_i[RF_BASE  + NCH - 1 - n];
        tie_q[n] <= wdata_i[TE_BASE  + NCH - 1 - n];
      end
      flag_q <= wdata_i[NFLAG-1:0];
    end
  end

  assign irq_o = |(gip_i & gie_q) | |(rx_full_i & rie_q) | |(~tx_full_i & tie_q);

  a_r4_enables_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_v[DW-1:TE_BASE] == $past(wdata_i[DW-1:TE_BASE]));
  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_q == '0 && rie_q == '0 && tie_q == '0) |-> !irq_o);
  a_r1_ctrl_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (gie_q == '0 && flag_q == '0));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] a_addr_i,
  input  logic          a_wr_i,
  input  logic          a_rd_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  output logic          a_irq_o,
  input  logic [AW-1:0] b_addr_i,
  input  logic          b_wr_i,
  input  logic          b_rd_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          b_irq_o
);
  logic [NCH-1:0]         a_tx_wr, a_rx_rd, a_gir_set, a_gip_clr;
  logic [NCH-1:0]         b_tx_wr, b_rx_rd, b_gir_set, b_gip_clr;
  logic [NFLAG-1:0]       a_flags, b_flags;
  logic [NCH-1:0]         ab_full, ba_full, ab_bell, ba_bell;
  logic [NCH-1:0][DW-1:0] ab_data, ba_data;

  mb_port u_port_a (
    .clk_i, .rst_ni,
    .addr_i(a_addr_i), .wr_i(a_wr_i), .rd_i(a_rd_i), .wdata_i(a_wdata_i),
    .rdata_o(a_rdata_o), .irq_o(a_irq_o),
    .tx_wr_o(a_tx_wr), .rx_rd_o(a_rx_rd), .gir_set_o(a_gir_set), .gip_clr_o(a_gip_clr),
    .flags_o(a_flags),
    .tx_full_i(ab_full), .rx_full_i(ba_full), .rx_data_i(ba_data),
    .gir_i(ab_bell), .gip_i(ba_bell), .peer_flags_i(b_flags)
  );

  mb_port u_port_b (
    .clk_i, .rst_ni,
    .addr_i(b_addr_i), .wr_i(b_wr_i), .rd_i(b_rd_i), .wdata_i(b_wdata_i),
    .rdata_o(b_rdata_o), .irq_o(b_irq_o),
    .tx_wr_o(b_tx_wr), .rx_rd_o(b_rx_rd), .gir_set_o(b_gir_set), .gip_clr_o(b_gip_clr),
    .flags_o(b_flags),
    .tx_full_i(ba_full), .rx_full_i(ab_full), .rx_data_i(ab_data),
    .gir_i(ba_bell), .gip_i(ab_bell), .peer_flags_i(a_flags)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    mb_lane #(.DW(DW)) u_lane_ab (
      .clk_i, .rst_ni, .wr_i(a_tx_wr[n]), .wdata_i(a_wdata_i),
      .rd_i(b_rx_rd[n]), .data_o(ab_data[n]), .full_o(ab_full[n])
    );
    mb_lane #(.DW(DW)) u_lane_ba (
      .clk_i, .rst_ni, .wr_i(b_tx_wr[n]), .wdata_i(b_wdata_i),
      .rd_i(a_rx_rd[n]), .data_o(ba_data[n]), .full_o(ba_full[n])
    );
    mb_bell u_bell_ab (
      .clk_i, .rst_ni, .set_i(a_gir_set[n]), .clr_i(b_gip_clr[n]), .pend_o(ab_bell[n])
    );
    mb_bell u_bell_ba (
      .clk_i, .rst_ni, .set_i(b_gir_set[n]), .clr_i(a_gip_clr[n]), .pend_o(ba_bell[n])
    );
  end

  a_r1_irq_low_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!a_irq_o && !b_irq_o));
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          side_q[$];

  always #2 clk = ~clk;

  ipc_mailbox u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_addr_i(a_addr), .a_wr_i(a_wr), .a_rd_i(a_rd), .a_wdata_i(a_wdata),
    .a_rdata_o(a_rdata), .a_irq_o(a_irq),
    .b_addr_i(b_addr), .b_wr_i(b_wr), .b_rd_i(b_rd), .b_wdata_i(b_wdata),
    .b_rdata_o(b_rdata), .b_irq_o(b_irq)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(bit side, logic [5:0] addr, logic [31:0] d);
    @(negedge clk);
    if (!side) begin a_addr = addr; a_wdata = d; a_wr = 1'b1; end
    else       begin b_addr = addr; b_wdata = d; b_wr = 1'b1; end
    @(negedge clk);
    a_wr = 1'b0;
    b_wr = 1'b0;
  endtask

  // driver: push expectation, then strobe the read
  task automatic rd(bit side, logic [5:0] addr, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    side_q.push_back(side);
    if (!side) begin a_addr = addr; a_rd = 1'b1; end
    else       begin b_addr = addr; b_rd = 1'b1; end
    @(negedge clk);
    a_rd = 1'b0;
    b_rd = 1'b0;
  endtask

  task automatic chk_irq(string tag, logic a_exp, logic b_exp);
    #1;
    chk({tag, " irq A"}, {31'd0, a_irq}, {31'd0, a_exp});
    chk({tag, " irq B"}, {31'd0, b_irq}, {31'd0, b_exp});
  endtask

  // monitor: pop and compare while a read strobe is active
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (a_rd || b_rd) begin
        if (exp_q.size() == 0) begin
          n_cmp++;
          n_bad++;
          $display("FAIL scoreboard: read with no expectation, actual %08h expected none",
                   a_rd ? a_rdata : b_rdata);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string       t = tag_q.pop_front();
          automatic bit          s = side_q.pop_front();
          chk(t, s ? b_rdata : a_rdata, e);
        end
      end
    end
  end

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  localparam logic [5:0] STAT = 6'h20, CTRL = 6'h24;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq("R1", 1'b0, 1'b0);
    rd(0, STAT, 32'h00F0_0000, "R1 A status");
    rd(1, STAT, 32'h00F0_0000, "R1 B status");
    rd(0, CTRL, 32'h0000_0000, "R1 A control");
    rd(1, CTRL, 32'h0000_0000, "R1 B control");

    // R2 A->B slot 1
    wr(0, 6'h04, 32'hDEAD_BEEF);
    rd(1, STAT, 32'h04F0_0000, "R2 B full bit 26");
    rd(0, STAT, 32'h00B0_0000, "R2 A empty bit 22 cleared");
    rd(1, 6'h14, 32'hDEAD_BEEF, "R2 B slot 1 data");
    // R3 the read above drains the slot
    rd(1, STAT, 32'h00F0_0000, "R3 B full cleared");
    rd(0, STAT, 32'h00F0_0000, "R3 A empty restored");

    // R2 B->A slot 3 with overwrite
    wr(1, 6'h0C, 32'h1234_5678);
    rd(1, STAT, 32'h00E0_0000, "R2 B empty bit 20 cleared");
    rd(0, STAT, 32'h01F0_0000, "R2 A full bit 24");
    wr(1, 6'h0C, 32'hCAFE_F00D);
    rd(0, STAT, 32'h01F0_0000, "R2 A still full after overwrite");
    rd(0, 6'h1C, 32'hCAFE_F00D, "R2 A slot 3 overwritten data");
    rd(0, STAT, 32'h00F0_0000, "R3 A full 3 cleared");

    // R4 / R7 empty interrupt on A slot 0
    wr(0, CTRL, 32'h0080_0000);
    rd(0, CTRL, 32'h0080_0000, "R4 A empty enable ch0 bit 23");
    chk_irq("R7 empty enabled", 1'b1, 1'b0);
    wr(0, 6'h00, 32'h0000_00AA);
    chk_irq("R7 empty cleared", 1'b0, 1'b0);
    rd(1, 6'h10, 32'h0000_00AA, "R2 B slot 0 data");
    chk_irq("R7 empty again", 1'b1, 1'b0);
    wr(0, CTRL, 32'h0000_0000);
    chk_irq("R7 masked", 1'b0, 1'b0);

    // R7 full interrupt on B slot 2
    wr(1, CTRL, 32'h0200_0000);
    rd(1, CTRL, 32'h0200_0000, "R4 B full enable ch2 bit 25");
    chk_irq("R7 full enabled idle", 1'b0, 1'b0);
    wr(0, 6'h08, 32'h5555_AAAA);
    chk_irq("R7 full raised", 1'b0, 1'b1);
    rd(1, 6'h18, 32'h5555_AAAA, "R2 B slot 2 data");
    chk_irq("R7 full drained", 1'b0, 1'b0);

    // R5 doorbell A->B ch3
    wr(0, CTRL, 32'h0001_0000);
    rd(0, CTRL, 32'h0001_0000, "R5 A request bit 16");
    rd(1, STAT, 32'h10F0_0000, "R5 B pending bit 28");
    chk_irq("R7 pending masked", 1'b0, 1'b0);
    wr(0, CTRL, 32'h0000_0000);
    rd(0, CTRL, 32'h0001_0000, "R5 request not withdrawn by 0");
    wr(1, CTRL, 32'h1200_0000);
    chk_irq("R7 pending enabled", 1'b0, 1'b1);

    // R6 write-one-to-clear
    wr(1, STAT, 32'h0000_0000);
    rd(1, STAT, 32'h10F0_0000, "R6 zero write keeps pending");
    wr(1, STAT, 32'h1000_0000);
    rd(1, STAT, 32'h00F0_0000, "R6 pending cleared");
    rd(0, CTRL, 32'h0000_0000, "R6 origin request cleared");
    chk_irq("R6 irq dropped", 1'b0, 1'b0);

    // R8 flags
    wr(0, CTRL, 32'h0000_0005);
    rd(1, STAT, 32'h00F0_0005, "R8 A flags seen on B");
    wr(1, CTRL, 32'h0000_0002);
    rd(0, STAT, 32'h00F0_0002, "R8 B flags seen on A");
    rd(0, CTRL, 32'h0000_0005, "R4 A flags readback");

    // R9 read-only status bits
    wr(1, 6'h00, 32'h0BAD_0001);
    rd(0, STAT, 32'h08F0_0002, "R9 A status before");
    wr(0, STAT, 32'hFFFF_FFFF);
    rd(0, STAT, 32'h08F0_0002, "R9 A status unchanged by ones");
    rd(0, 6'h10, 32'h0BAD_0001, "R9 A slot 0 data intact");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule